// File: doc/BRIEF.md
# Oversampled Nine-Bit Serial Receiver

This block turns an asynchronous serial line into parallel characters for a multi-drop link, where each character can optionally carry a ninth bit that marks it as an address. It is clocked by the system clock and advances its bit timing only on a one-cycle sampling tick supplied at sixteen times the baud rate. Baud generation, character buffering and address filtering belong to neighbouring blocks.

After two synchronizer stages, a falling edge on the idle-high line starts a candidate frame, provided both enables are high. The line is looked at again half a bit later to reject noise. Every later bit is judged by a two-out-of-three vote over three consecutive mid-bit samples. The data byte arrives least-significant bit first. In nine-bit mode an address-indicator bit follows the byte, and the stop bit comes last. Each finished frame is reported by a one-cycle valid strobe together with the byte, the address flag and a framing-error flag.

Top module: `rx9Top`

## Requirements
- R1: While reset is held and directly after it, rxValid, rxData, rxAddrFlag and rxFrameErr are all 0.
- R2: A falling edge on serialIn starts a frame only when uartEnable and rxEnable are both 1. A frame sent while either enable is 0 produces no strobe.
- R3: Ticks are counted from the detected falling edge starting at 0. The line is rechecked on the tick where the count is 7. If the line is high there, the frame is dropped with no strobe, and a following good frame is received normally.
- R4: With nineBitMode = 0 the frame is start, 8 data bits least-significant first, stop. The byte appears on rxData and rxAddrFlag is 0.
- R5: With nineBitMode = 1 a ninth bit sits between the last data bit and the stop bit. It appears on rxAddrFlag (1 = address character, 0 = data character).
- R6: Each bit after the start bit is sampled on the ticks at counts 7, 8 and 9 of its 16-tick period and decided by majority. One disagreeing sample leaves the bit unchanged, and two disagreeing samples flip it.
- R7: rxFrameErr is 1 on the strobe of a frame whose stop-bit majority is 0, and 0 when it is 1.
- R8: rxValid is high for exactly one cycle per frame. It is sampled high in the second clock cycle after the edge that consumes the tick carrying the stop bit's third sample.
- R9: Dropping either enable in the middle of a frame abandons that frame with no strobe.
- R10: The frame format is fixed by nineBitMode at the falling edge. A change of nineBitMode during the frame has no effect on that frame.
- R11: rxData, rxAddrFlag and rxFrameErr hold their values between strobes. Dropped or abandoned frames do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| uartEnable | input | 1 | Global enable for the serial unit |
| rxEnable | input | 1 | Receive enable |
| sampleTick | input | 1 | One-cycle pulse at 16x the baud rate |
| nineBitMode | input | 1 | 1 selects frames with the address-indicator bit |
| rxData | output | 8 | Last received byte |
| rxAddrFlag | output | 1 | Address-indicator bit of the last character |
| rxFrameErr | output | 1 | Stop bit of the last character was low |
| rxValid | output | 1 | One-cycle strobe for a new character |

## Verification
The bench counts sampling ticks from each bit boundary it drives. It notes the clock count after the tenth tick of the stop bit, which is the tick of the third stop sample. It then requires the only strobe of that frame to be sampled exactly one clock count later, at a falling clock edge. Line changes are made one nanosecond after a tick edge, so the two synchronizer stages always settle well before the next tick. Because of that, mid-bit glitches placed after tick 8 land exactly on the samples at counts 8 and 9. Negative cases (glitch start, disabled or abandoned frames) wait out the whole frame length plus idle ticks before asserting that no strobe came and the outputs kept their values.

// File: rtl/rx9Pkg.sv
package rx9Pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_RECV,
    RX_SAVE
  } rxState_e;

  // control-to-datapath strobes, each valid for one clock
  typedef struct packed {
    logic clearFrame;  // start bit accepted
    logic sampA;       // first mid-bit sample
    logic sampB;       // second mid-bit sample
    logic takeData;    // vote into data shift register
    logic takeAddr;    // vote into address-indicator bit
    logic takeStop;    // vote into stop bit
    logic loadOut;     // present the assembled character
  } rxStrobe_t;

endpackage

// File: rtl/rx9Sync.sv
module rx9Sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serialIn,
  output logic lineSync
);
  logic [STAGES-1:0] syncReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '1;
    else       syncReg <= {syncReg[STAGES-2:0], serialIn};
  end

  assign lineSync = syncReg[STAGES-1];
endmodule

// File: rtl/rx9Ctrl.sv
module rx9Ctrl
  import rx9Pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineSync,
  input  logic      uartEnable,
  input  logic      rxEnable,
  input  logic      sampleTick,
  input  logic      nineBitMode,
  output rxStrobe_t strb,
  output logic      mode9
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_BITS + 3);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] SECOND_CNT = CNT_W'(OVERSAMPLE / 2);
  localparam logic [CNT_W-1:0] TAKE_CNT = CNT_W'(OVERSAMPLE / 2 + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_BITS);
  localparam logic [IDX_W-1:0] ADDR_IDX = IDX_W'(DATA_BITS + 1);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(DATA_BITS + 2);

  rxState_e         state, stateNext;
  logic [CNT_W-1:0] tickCnt, tickCntNext;
  logic [IDX_W-1:0] bitIdx, bitIdxNext;
  logic             modeNext;
  logic             linePrev;
  logic             enabled;

  assign enabled = uartEnable & rxEnable;

  always_comb begin
    stateNext   = state;
    tickCntNext = tickCnt;
    bitIdxNext  = bitIdx;
    modeNext    = mode9;
    strb        = '0;
    unique case (state)
      RX_IDLE: begin
        if (enabled && linePrev && !lineSync) begin
          stateNext   = RX_START;
          tickCntNext = '0;
          modeNext    = nineBitMode;
        end
      end
      RX_START: begin
        if (!enabled) begin
          stateNext = RX_IDLE;
        end else if (sampleTick) begin
          tickCntNext = tickCnt + 1'b1;
          if (tickCnt == HALF_CNT) begin
            if (!lineSync) begin
              stateNext       = RX_RECV;
              bitIdxNext      = '0;
              strb.clearFrame = 1'b1;
            end else begin
              stateNext = RX_IDLE;
            end
          end
        end
      end
      RX_RECV: begin
        if (!enabled) begin
          stateNext = RX_IDLE;
        end else if (sampleTick) begin
          if (tickCnt == LAST_CNT) begin
            tickCntNext = '0;
            bitIdxNext  = bitIdx + 1'b1;
          end else begin
            tickCntNext = tickCnt + 1'b1;
          end
          if (bitIdx != '0) begin
            strb.sampA = (tickCnt == HALF_CNT);
            strb.sampB = (tickCnt == SECOND_CNT);
            if (tickCnt == TAKE_CNT) begin
              if (bitIdx <= DATA_LAST) begin
                strb.takeData = 1'b1;
              end else if (mode9 && bitIdx == ADDR_IDX) begin
                strb.takeAddr = 1'b1;
              end else begin
                strb.takeStop = 1'b1;
                stateNext     = RX_SAVE;
              end
            end
          end
        end
      end
      RX_SAVE: begin
        strb.loadOut = 1'b1;
        stateNext    = RX_IDLE;
      end
      default: stateNext = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= RX_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      mode9    <= 1'b0;
      linePrev <= 1'b1;
    end else begin
      state    <= stateNext;
      tickCnt  <= tickCntNext;
      bitIdx   <= bitIdxNext;
      mode9    <= modeNext;
      linePrev <= lineSync;
    end
  end

  // R2
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_START && $past(state) == RX_IDLE) |-> $past(uartEnable && rxEnable));

  // R9
  abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(uartEnable && rxEnable) |=> state == RX_IDLE);

  // R3
  start_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == RX_START |-> tickCnt <= HALF_CNT);

  // R5
  bit_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == RX_RECV |-> bitIdx <= IDX_MAX);
endmodule

// File: rtl/rx9Datapath.sv
module rx9Datapath
  import rx9Pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineSync,
  input  rxStrobe_t            strb,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxAddrFlag,
  output logic                 rxFrameErr,
  output logic                 rxValid
);
  logic                 sampleA, sampleB;
  logic                 vote;
  logic [DATA_BITS-1:0] shiftReg;
  logic                 addrBit;
  logic                 stopBit;

  // two of three: the samples at counts 7 and 8 plus the live one at count 9
  assign vote = (sampleA & sampleB) | (sampleA & lineSync) | (sampleB & lineSync);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleA  <= 1'b1;
      sampleB  <= 1'b1;
      shiftReg <= '0;
      addrBit  <= 1'b0;
      stopBit  <= 1'b1;
    end else begin
      if (strb.sampA) sampleA <= lineSync;
      if (strb.sampB) sampleB <= lineSync;
      if (strb.clearFrame) addrBit <= 1'b0;
      else if (strb.takeAddr) addrBit <= vote;
      if (strb.takeData) shiftReg <= {vote, shiftReg[DATA_BITS-1:1]};
      if (strb.takeStop) stopBit <= vote;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxAddrFlag <= 1'b0;
      rxFrameErr <= 1'b0;
      rxValid    <= 1'b0;
    end else begin
      rxValid <= strb.loadOut;
      if (strb.loadOut) begin
        rxData     <= shiftReg;
        rxAddrFlag <= addrBit;
        rxFrameErr <= ~stopBit;
      end
    end
  end

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R11
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> ($stable(rxData) && $stable(rxAddrFlag) && $stable(rxFrameErr)));
endmodule

// File: rtl/rx9Top.sv
module rx9Top
  import rx9Pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serialIn,
  input  logic                 uartEnable,
  input  logic                 rxEnable,
  input  logic                 sampleTick,
  input  logic                 nineBitMode,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxAddrFlag,
  output logic                 rxFrameErr,
  output logic                 rxValid
);
  logic      lineSync;
  logic      mode9;
  rxStrobe_t strb;

  rx9Sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .serialIn (serialIn),
    .lineSync (lineSync)
  );

  rx9Ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .lineSync    (lineSync),
    .uartEnable  (uartEnable),
    .rxEnable    (rxEnable),
    .sampleTick  (sampleTick),
    .nineBitMode (nineBitMode),
    .strb        (strb),
    .mode9       (mode9)
  );

  rx9Datapath #(.DATA_BITS(DATA_BITS)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .lineSync   (lineSync),
    .strb       (strb),
    .rxData     (rxData),
    .rxAddrFlag (rxAddrFlag),
    .rxFrameErr (rxFrameErr),
    .rxValid    (rxValid)
  );

  // R4
  addr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !mode9) |-> !rxAddrFlag);
endmodule

// File: tb/rx9Top_test.sv
module rx9Top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serialIn = 1'b1;
  logic       uartEnable = 1'b1;
  logic       rxEnable = 1'b1;
  logic       sampleTick = 1'b0;
  logic       nineBitMode = 1'b0;
  logic [7:0] rxData;
  logic       rxAddrFlag, rxFrameErr, rxValid;

  int checks = 0;
  int failures = 0;
  int cycCount = 0;
  int divCnt = 0;
  int validCount = 0;
  int lastValidCycle = -1;
  int stopCycle = 0;
  logic [7:0] lastData = '0;
  logic lastAddr = 1'b0, lastErr = 1'b0;
  bit done = 1'b0;

  rx9Top uut (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .uartEnable(uartEnable),
    .rxEnable(rxEnable), .sampleTick(sampleTick), .nineBitMode(nineBitMode),
    .rxData(rxData), .rxAddrFlag(rxAddrFlag), .rxFrameErr(rxFrameErr), .rxValid(rxValid)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cycCount <= cycCount + 1;

  // one tick every 8 clocks, changed on falling edges
  always @(negedge clk) begin
    divCnt = (divCnt + 1) % 8;
    sampleTick = (divCnt == 0);
  end

  always @(negedge clk) begin
    if (rstN && rxValid) begin
      validCount++;
      lastValidCycle = cycCount;
      lastData = rxData;
      lastAddr = rxAddrFlag;
      lastErr = rxFrameErr;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, actual, expected);
    end
  endtask

  task automatic waitTick();
    forever begin
      @(posedge clk);
      if (sampleTick) break;
    end
    #1;
  endtask

  task automatic idleTicks(input int n);
    for (int i = 0; i < n; i++) waitTick();
  endtask

  // bit 0 = start, 1..8 data, 9 = address bit when nine, last = stop
  task automatic sendFrame(input logic [7:0] d, input bit nine, input bit addr,
                           input bit stopV, input int glitchBit, input int glitchLen,
                           input int dropBit, input int flipBit);
    int nBits;
    nBits = nine ? 11 : 10;
    for (int b = 0; b < nBits; b++) begin
      logic v;
      if (b == 0) v = 1'b0;
      else if (b <= 8) v = d[b-1];
      else if (nine && b == 9) v = addr;
      else v = stopV;
      serialIn = v;
      if (b == dropBit) uartEnable = 1'b0;
      if (b == flipBit) nineBitMode = ~nineBitMode;
      for (int t = 1; t <= 16; t++) begin
        waitTick();
        if (b == nBits - 1 && t == 10) stopCycle = cycCount;
        if (b == glitchBit && t == 8) serialIn = ~v;
        if (b == glitchBit && t == 8 + glitchLen) serialIn = v;
      end
    end
    serialIn = 1'b1;
    idleTicks(4);
  endtask

  task automatic expectFrame(input string tag, input int base, input logic [7:0] d,
                             input bit a, input bit e);
    check(validCount == base + 1, tag, "strobe count", validCount - base, 1);
    check(lastData == d, tag, "data", lastData, d);
    check(lastAddr == a, tag, "address flag", lastAddr, a);
    check(lastErr == e, tag, "framing error", lastErr, e);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(rxValid == 1'b0 && rxData == 8'h00 && rxAddrFlag == 1'b0 && rxFrameErr == 1'b0,
          "R1", "outputs in reset", {rxValid, rxAddrFlag, rxFrameErr, rxData}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rxValid == 1'b0 && rxData == 8'h00, "R1", "outputs after reset",
          {rxValid, rxData}, 0);
    idleTicks(3);
  endtask

  task automatic testEightBit(input logic [7:0] d);
    int base = validCount;
    nineBitMode = 1'b0;
    sendFrame(d, 1'b0, 1'b0, 1'b1, -1, 0, -1, -1);
    expectFrame("R4", base, d, 1'b0, 1'b0);
    // R8: strobe timing relative to the stop-bit third sample
    check(lastValidCycle == stopCycle + 1, "R8", "strobe cycle", lastValidCycle, stopCycle + 1);
  endtask

  task automatic testNineBit(input logic [7:0] d, input bit a);
    int base = validCount;
    nineBitMode = 1'b1;
    sendFrame(d, 1'b1, a, 1'b1, -1, 0, -1, -1);
    expectFrame("R5", base, d, a, 1'b0);
    check(lastValidCycle == stopCycle + 1, "R8", "strobe cycle 9-bit", lastValidCycle, stopCycle + 1);
    nineBitMode = 1'b0;
  endtask

  task automatic testFrameErr();
    int base = validCount;
    nineBitMode = 1'b1;
    sendFrame(8'h37, 1'b1, 1'b1, 1'b0, -1, 0, -1, -1);
    expectFrame("R7", base, 8'h37, 1'b1, 1'b1);
    base = validCount;
    sendFrame(8'h37, 1'b1, 1'b0, 1'b1, -1, 0, -1, -1);
    expectFrame("R7", base, 8'h37, 1'b0, 1'b0);
    nineBitMode = 1'b0;
  endtask

  task automatic testStartGlitch();
    int base = validCount;
    logic [7:0] held = rxData;
    serialIn = 1'b0;
    idleTicks(7);
    serialIn = 1'b1;
    idleTicks(24);
    check(validCount == base, "R3", "glitch start strobes", validCount - base, 0);
    check(rxData == held, "R11", "data after glitch", rxData, held);
    base = validCount;
    sendFrame(8'h69, 1'b0, 1'b0, 1'b1, -1, 0, -1, -1);
    expectFrame("R3", base, 8'h69, 1'b0, 1'b0);
  endtask

  task automatic testDisabled();
    int base = validCount;
    logic [7:0] held = rxData;
    rxEnable = 1'b0;
    sendFrame(8'h12, 1'b0, 1'b0, 1'b1, -1, 0, -1, -1);
    rxEnable = 1'b1;
    check(validCount == base, "R2", "strobe with receive disabled", validCount - base, 0);
    uartEnable = 1'b0;
    sendFrame(8'h34, 1'b0, 1'b0, 1'b1, -1, 0, -1, -1);
    uartEnable = 1'b1;
    check(validCount == base, "R2", "strobe with unit disabled", validCount - base, 0);
    check(rxData == held, "R11", "data after disabled frames", rxData, held);
  endtask

  task automatic testMajority();
    int base = validCount;
    // one bad sample on bit index 4 (d[3] = 0)
    sendFrame(8'hF0, 1'b0, 1'b0, 1'b1, 4, 1, -1, -1);
    expectFrame("R6", base, 8'hF0, 1'b0, 1'b0);
    base = validCount;
    // two bad samples on bit index 5 (d[4] = 1) flip it
    sendFrame(8'hF0, 1'b0, 1'b0, 1'b1, 5, 2, -1, -1);
    expectFrame("R6", base, 8'hE0, 1'b0, 1'b0);
  endtask

  task automatic testAbort();
    int base = validCount;
    logic [7:0] held = rxData;
    logic heldErr = rxFrameErr;
    sendFrame(8'h5C, 1'b0, 1'b0, 1'b1, -1, 0, 3, -1);
    uartEnable = 1'b1;
    idleTicks(4);
    check(validCount == base, "R9", "strobe after abort", validCount - base, 0);
    check(rxData == held && rxFrameErr == heldErr, "R11", "outputs after abort",
          {rxFrameErr, rxData}, {heldErr, held});
  endtask

  task automatic testModeLatch();
    int base = validCount;
    nineBitMode = 1'b1;
    sendFrame(8'hC3, 1'b1, 1'b1, 1'b1, -1, 0, -1, 2);
    expectFrame("R10", base, 8'hC3, 1'b1, 1'b0);
    nineBitMode = 1'b0;
  endtask

  task automatic testBackToBack();
    int base = validCount;
    int firstCycle;
    nineBitMode = 1'b0;
    serialIn = 1'b0;
    sendFrame(8'h0F, 1'b0, 1'b0, 1'b1, -1, 0, -1, -1);
    firstCycle = lastValidCycle;
    sendFrame(8'hB4, 1'b0, 1'b0, 1'b1, -1, 0, -1, -1);
    check(validCount == base + 2, "R8", "one strobe per frame", validCount - base, 2);
    check(lastData == 8'hB4 && firstCycle != lastValidCycle, "R4", "second frame data",
          lastData, 8'hB4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testEightBit(8'hA5);
    testEightBit(8'h3C);
    testNineBit(8'h5A, 1'b1);
    testNineBit(8'h81, 1'b0);
    testFrameErr();
    testStartGlitch();
    testDisabled();
    testMajority();
    testAbort();
    testModeLatch();
    testBackToBack();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule